// File: doc/BRIEF.md
# Dual Event-Selectable Performance Counters

This block holds two independent 32-bit event counters that watch the pipeline. Each counter has its own control register with a 4-bit event-select field. The selected event decides three things: which per-cycle pipeline signal is counted, how much is added, and in which cycle the addition lands. Both the control registers and the counts can be written and read through a simple single-cycle register port.

The pipeline supplies these signals:
- store and store-conditional issue pulses, with a flag that marks an issue as a repeat;
- store and store-conditional graduation pulses;
- a store-conditional failure pulse;
- a 0-to-4 count of floating-point instructions that graduated;
- a count of conditional branches that resolved.

Some events are added at the edge that samples them. Others go through a one-stage pipeline register and are added one edge later. When a count wraps past its all-ones value, a sticky overflow flag is set for that counter. Software clears the flag by writing 1 to it.

Top module: `perf_counter_pair`

## Requirements
- R1: After reset, both counts, both select fields and both overflow flags are 0, and all four register addresses read 0.
- R2: Register addresses are 0 = control 0, 1 = count 0, 2 = control 1, 3 = count 1. A control register reads back its select in bits [3:0] and its overflow flag in bit 8. A count register reads back its current value. A count write takes effect at the next edge, and it wins over any increment due in that same cycle.
- R3: Counter 0 with select 3 adds 1 for each store issue pulse (store-conditionals included) that is not flagged as a re-issue. The increment appears one edge after the edge that samples the pulse, and consecutive issues each count.
- R4: Counter 0 with select 4 adds 1 for each store-conditional issue that is not flagged as a re-issue. This uses the same one-edge delay as R3. A plain store issue does not count.
- R5: Counter 0 with select 5 adds 1 for each store-conditional failure pulse. The increment is visible right after the edge that samples the pulse.
- R6: Counter 0 with select 6 adds exactly 1 in any cycle where the resolved-branch count is nonzero, whatever its value. The increment is visible right after the sampling edge, and a zero count adds nothing.
- R7: Counter 1 with select 3 adds 1 per store graduation pulse. The increment is visible right after the sampling edge.
- R8: Counter 1 with select 4 adds 1 per store-conditional graduation pulse, one edge after the sampling edge. A plain store graduation does not count.
- R9: Counter 1 with select 5 adds the graduated floating-point count, one edge after the sampling edge. Input values above 4 are added as 4.
- R10: Selects other than 3 to 6 for counter 0, and other than 3 to 5 for counter 1, leave that count unchanged whatever the event inputs do.
- R11: An increment that carries out of bit 31 sets the counter's sticky overflow flag, shown on ovf_o and in control bit 8. Writing the control register with bit 8 = 1 clears the flag. Writing it with bit 8 = 0 leaves the flag set.
- R12: In a cycle where a counter's control register is written, that counter takes no increment. Any delayed increment still in flight for it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |
| st_issue_i | input | 1 | A store (any kind) issued to address calculation this cycle |
| sc_issue_i | input | 1 | The issued store is a store-conditional |
| reissue_i | input | 1 | This issue repeats an already issued instruction |
| st_grad_i | input | 1 | A store (any kind) graduated this cycle |
| sc_grad_i | input | 1 | A store-conditional graduated this cycle |
| sc_fail_i | input | 1 | A store-conditional failed this cycle |
| fp_grad_cnt_i | input | 3 | Floating-point instructions graduated this cycle |
| br_resolved_cnt_i | input | 3 | Conditional branches resolved this cycle |
| ovf_o | output | 2 | Sticky overflow flag for each counter |

## Verification
Immediate events (R5, R6, R7) are due after the first rising edge that samples them. Delayed events (R3, R4, R8, R9) are due one edge later. Register writes, overflow set and overflow clear are due at the edge of the write or increment.

The bench drives every input at a falling edge and reads back at later falling edges. For each delayed event it checks the count both after the first edge, where it must still be unchanged, and after the second edge. Table vectors wait two edges before reading so that either timing has landed. The flush and write-priority cases put the write into exactly the cycle where the pending increment would have been applied.

// File: rtl/perf_pkg.sv
package perf_pkg;

  localparam int OVF_BIT = 8;
  localparam int FP_MAX  = 4;

  typedef enum logic [1:0] {
    ADDR_CTL0 = 2'd0,
    ADDR_CNT0 = 2'd1,
    ADDR_CTL1 = 2'd2,
    ADDR_CNT1 = 2'd3
  } reg_addr_e;

  // counter 0 selects
  localparam logic [3:0] SEL0_ST_ISSUE = 4'd3;
  localparam logic [3:0] SEL0_SC_ISSUE = 4'd4;
  localparam logic [3:0] SEL0_SC_FAIL  = 4'd5;
  localparam logic [3:0] SEL0_BR_RESLV = 4'd6;
  // counter 1 selects
  localparam logic [3:0] SEL1_ST_GRAD  = 4'd3;
  localparam logic [3:0] SEL1_SC_GRAD  = 4'd4;
  localparam logic [3:0] SEL1_FP_GRAD  = 4'd5;

  typedef struct packed {
    logic       st_issue;
    logic       sc_issue;
    logic       reissue;
    logic       st_grad;
    logic       sc_grad;
    logic       sc_fail;
    logic [2:0] fp_cnt;
    logic [2:0] br_cnt;
  } evt_t;

endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel
  import perf_pkg::*;
#(
  parameter int UNIT  = 0,
  parameter int SEL_W = 4,
  parameter int INC_W = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  input  evt_t             evt_i,
  output logic [INC_W-1:0] now_amt_o,
  output logic [INC_W-1:0] dly_amt_o
);

  logic first_issue;
  logic [INC_W-1:0] fp_clamped;

  assign first_issue = evt_i.st_issue & ~evt_i.reissue;
  assign fp_clamped  = (evt_i.fp_cnt > 3'(FP_MAX)) ? INC_W'(FP_MAX) : INC_W'(evt_i.fp_cnt);

  if (UNIT == 0) begin : g_unit0
    always_comb begin
      now_amt_o = '0;
      dly_amt_o = '0;
      case (sel_i)
        SEL_W'(SEL0_ST_ISSUE): dly_amt_o = INC_W'(first_issue);
        SEL_W'(SEL0_SC_ISSUE): dly_amt_o = INC_W'(first_issue & evt_i.sc_issue);
        SEL_W'(SEL0_SC_FAIL):  now_amt_o = INC_W'(evt_i.sc_fail);
        SEL_W'(SEL0_BR_RESLV): now_amt_o = INC_W'(|evt_i.br_cnt);  // saturate at one
        default: ;
      endcase
    end
  end else begin : g_unit1
    always_comb begin
      now_amt_o = '0;
      dly_amt_o = '0;
      case (sel_i)
        SEL_W'(SEL1_ST_GRAD): now_amt_o = INC_W'(evt_i.st_grad);
        SEL_W'(SEL1_SC_GRAD): dly_amt_o = INC_W'(evt_i.sc_grad);
        SEL_W'(SEL1_FP_GRAD): dly_amt_o = fp_clamped;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/perf_dly_stage.sv
module perf_dly_stage #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [W-1:0] amt_i,
  output logic [W-1:0] amt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      amt_o <= '0;
    else if (flush_i) amt_o <= '0;
    else              amt_o <= amt_i;
  end

endmodule

// File: rtl/perf_cnt_reg.sv
module perf_cnt_reg #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             hold_i,
  input  logic [INC_W:0]   inc_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W:0] sum;
  logic           bump;

  assign sum  = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);
  assign bump = ~ld_i & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (ld_i) cnt_o <= ld_val_i;
    else if (bump) cnt_o <= sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_o <= 1'b0;
    else if (bump && sum[CNT_W]) ovf_o <= 1'b1;
    else if (ovf_clr_i)          ovf_o <= 1'b0;
  end

endmodule

// File: rtl/perf_counter_pair.sv
module perf_counter_pair
  import perf_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             st_issue_i,
  input  logic             sc_issue_i,
  input  logic             reissue_i,
  input  logic             st_grad_i,
  input  logic             sc_grad_i,
  input  logic             sc_fail_i,
  input  logic [2:0]       fp_grad_cnt_i,
  input  logic [2:0]       br_resolved_cnt_i,
  output logic [1:0]       ovf_o
);

  localparam int N_CNT = 2;

  evt_t evt;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_val;
  logic [N_CNT-1:0][SEL_W-1:0] sel_val;

  assign evt = '{st_issue: st_issue_i, sc_issue: sc_issue_i, reissue: reissue_i,
                 st_grad: st_grad_i, sc_grad: sc_grad_i, sc_fail: sc_fail_i,
                 fp_cnt: fp_grad_cnt_i, br_cnt: br_resolved_cnt_i};

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    logic             ctl_wr, cnt_wr;
    logic [SEL_W-1:0] sel_q;
    logic [INC_W-1:0] now_amt, dly_amt, dly_q;
    logic [INC_W:0]   inc;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    assign ctl_wr = wr_en_i && (wr_addr_i == {k[0], 1'b0});
    assign cnt_wr = wr_en_i && (wr_addr_i == {k[0], 1'b1});

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_q <= '0;
      else if (ctl_wr) sel_q <= wr_data_i[SEL_W-1:0];
    end

    perf_evt_sel #(.UNIT(k), .SEL_W(SEL_W), .INC_W(INC_W)) i_sel (
      .sel_i     (sel_q),
      .evt_i     (evt),
      .now_amt_o (now_amt),
      .dly_amt_o (dly_amt)
    );

    perf_dly_stage #(.W(INC_W)) i_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (ctl_wr),
      .amt_i   (dly_amt),
      .amt_o   (dly_q)
    );

    assign inc = {1'b0, now_amt} + {1'b0, dly_q};

    perf_cnt_reg #(.CNT_W(CNT_W), .INC_W(INC_W)) i_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (cnt_wr),
      .ld_val_i  (wr_data_i),
      .hold_i    (ctl_wr),
      .inc_i     (inc),
      .ovf_clr_i (ctl_wr & wr_data_i[OVF_BIT]),
      .cnt_o     (cnt_q),
      .ovf_o     (ovf_q)
    );

    assign cnt_val[k] = cnt_q;
    assign sel_val[k] = sel_q;
    assign ovf_o[k]   = ovf_q;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_CTL0: begin
        rd_data_o[SEL_W-1:0] = sel_val[0];
        rd_data_o[OVF_BIT]   = ovf_o[0];
      end
      ADDR_CNT0: rd_data_o = cnt_val[0];
      ADDR_CTL1: begin
        rd_data_o[SEL_W-1:0] = sel_val[1];
        rd_data_o[OVF_BIT]   = ovf_o[1];
      end
      default:   rd_data_o = cnt_val[1];
    endcase
  end

endmodule

// File: rtl/perf_counter_pair_chk.sv
module perf_counter_pair_chk #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [1:0]            wr_addr_i,
  input logic [CNT_W-1:0]      wr_data_i,
  input logic [1:0]            ovf_o,
  input logic [1:0][CNT_W-1:0] cnt_val,
  input logic [1:0][SEL_W-1:0] sel_val
);

  logic sel0_idle, sel1_idle;
  assign sel0_idle = (sel_val[0] < SEL_W'(3)) || (sel_val[0] > SEL_W'(6));
  assign sel1_idle = (sel_val[1] < SEL_W'(3)) || (sel_val[1] > SEL_W'(5));

  // R2
  cnt0_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1) |=> (cnt_val[0] == $past(wr_data_i)));

  // R2
  cnt1_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> (cnt_val[1] == $past(wr_data_i)));

  // R11
  ovf0_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o[0]) |-> $past(cnt_val[0][CNT_W-1]));

  // R11
  ovf0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o[0] && !(wr_en_i && wr_addr_i == 2'd0 && wr_data_i[8])) |=> ovf_o[0]);

  // R11
  ovf1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o[1] && !(wr_en_i && wr_addr_i == 2'd2 && wr_data_i[8])) |=> ovf_o[1]);

  // R10
  idle0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_idle && !wr_en_i) |=> $stable(cnt_val[0]));

  // R10
  idle1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel1_idle && !wr_en_i) |=> $stable(cnt_val[1]));

  // R6
  br_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_val[0] == SEL_W'(6) && !wr_en_i) |=>
      (CNT_W'(cnt_val[0] - $past(cnt_val[0])) <= CNT_W'(1)));

  // R9
  fp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_val[1] == SEL_W'(5) && !wr_en_i) |=>
      (CNT_W'(cnt_val[1] - $past(cnt_val[1])) <= CNT_W'(4)));

  // R12
  ctl0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0) |=> $stable(cnt_val[0]));

endmodule

bind perf_counter_pair perf_counter_pair_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ovf_o     (ovf_o),
  .cnt_val   (cnt_val),
  .sel_val   (sel_val)
);

// File: tb/test_perf_counter_pair.sv
`timescale 1ns/100ps
module test_perf_counter_pair;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        st_issue_i, sc_issue_i, reissue_i, st_grad_i, sc_grad_i, sc_fail_i;
  logic [2:0]  fp_grad_cnt_i, br_resolved_cnt_i;
  logic [1:0]  ovf_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  perf_counter_pair i_perf_counter_pair (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .st_issue_i, .sc_issue_i, .reissue_i, .st_grad_i, .sc_grad_i, .sc_fail_i,
    .fp_grad_cnt_i, .br_resolved_cnt_i, .ovf_o
  );

  typedef struct packed {
    logic       idx;
    logic [3:0] sel;
    logic [5:0] pulses;  // st_issue, sc_issue, reissue, st_grad, sc_grad, sc_fail
    logic [2:0] fp;
    logic [2:0] br;
    logic [2:0] exp_d;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd3, 6'b100000, 3'd0, 3'd0, 3'd1, 4'd3},   // R3 store issue
    '{1'b0, 4'd3, 6'b101000, 3'd0, 3'd0, 3'd0, 4'd3},   // R3 re-issue ignored
    '{1'b0, 4'd4, 6'b110000, 3'd0, 3'd0, 3'd1, 4'd4},   // R4 sc issue
    '{1'b0, 4'd4, 6'b100000, 3'd0, 3'd0, 3'd0, 4'd4},   // R4 plain store ignored
    '{1'b0, 4'd4, 6'b111000, 3'd0, 3'd0, 3'd0, 4'd4},   // R4 sc re-issue ignored
    '{1'b0, 4'd5, 6'b000001, 3'd0, 3'd0, 3'd1, 4'd5},   // R5 sc fail
    '{1'b0, 4'd6, 6'b000000, 3'd0, 3'd3, 3'd1, 4'd6},   // R6 three branches -> 1
    '{1'b0, 4'd6, 6'b000000, 3'd0, 3'd0, 3'd0, 4'd6},   // R6 none
    '{1'b1, 4'd3, 6'b000100, 3'd0, 3'd0, 3'd1, 4'd7},   // R7 store grad
    '{1'b1, 4'd4, 6'b000110, 3'd0, 3'd0, 3'd1, 4'd8},   // R8 sc grad
    '{1'b1, 4'd4, 6'b000100, 3'd0, 3'd0, 3'd0, 4'd8},   // R8 plain grad ignored
    '{1'b1, 4'd5, 6'b000000, 3'd4, 3'd0, 3'd4, 4'd9},   // R9 four fp
    '{1'b1, 4'd5, 6'b000000, 3'd7, 3'd0, 3'd4, 4'd9},   // R9 clamp
    '{1'b1, 4'd5, 6'b000000, 3'd2, 3'd0, 3'd2, 4'd9},   // R9 two fp
    '{1'b0, 4'd0, 6'b111111, 3'd7, 3'd7, 3'd0, 4'd10},  // R10 sel 0
    '{1'b1, 4'd6, 6'b111111, 3'd7, 3'd7, 3'd0, 4'd10}   // R10 sel 6 on counter 1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic clr_evt();
    {st_issue_i, sc_issue_i, reissue_i, st_grad_i, sc_grad_i, sc_fail_i} = '0;
    fp_grad_cnt_i = '0;
    br_resolved_cnt_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    clr_evt();
    repeat (3) @(negedge clk_i);
    // R1 during reset
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 reset ovf", 32'(ovf_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd1, d); check("R1 cnt0 after release", d, 32'h0);
    rd(2'd3, d); check("R1 cnt1 after release", d, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      wr({v.idx, 1'b0}, 32'(v.sel));
      wr({v.idx, 1'b1}, 32'h0);
      {st_issue_i, sc_issue_i, reissue_i, st_grad_i, sc_grad_i, sc_fail_i} = v.pulses;
      fp_grad_cnt_i = v.fp;
      br_resolved_cnt_i = v.br;
      @(negedge clk_i);
      clr_evt();
      repeat (2) @(negedge clk_i);
      rd({v.idx, 1'b1}, d);
      check($sformatf("R%0d vector %0d", v.req, i), d, 32'(v.exp_d));
    end

    // R3 delayed timing and back-to-back issues
    wr(2'd0, 32'd3); wr(2'd1, 32'd0);
    st_issue_i = 1'b1;
    @(negedge clk_i);
    rd(2'd1, d); check("R3 not before delay", d, 32'd0);
    @(negedge clk_i);
    clr_evt();
    rd(2'd1, d); check("R3 first issue landed", d, 32'd1);
    @(negedge clk_i);
    rd(2'd1, d); check("R3 second issue landed", d, 32'd2);

    // R5 immediate timing
    wr(2'd0, 32'd5); wr(2'd1, 32'd0);
    sc_fail_i = 1'b1;
    @(negedge clk_i);
    clr_evt();
    rd(2'd1, d); check("R5 immediate", d, 32'd1);

    // R7 immediate timing
    wr(2'd2, 32'd3); wr(2'd3, 32'd0);
    st_grad_i = 1'b1;
    @(negedge clk_i);
    clr_evt();
    rd(2'd3, d); check("R7 immediate", d, 32'd1);

    // R8 delayed timing
    wr(2'd2, 32'd4); wr(2'd3, 32'd0);
    sc_grad_i = 1'b1; st_grad_i = 1'b1;
    @(negedge clk_i);
    clr_evt();
    rd(2'd3, d); check("R8 not before delay", d, 32'd0);
    @(negedge clk_i);
    rd(2'd3, d); check("R8 landed", d, 32'd1);

    // R9 delayed timing
    wr(2'd2, 32'd5); wr(2'd3, 32'd0);
    fp_grad_cnt_i = 3'd3;
    @(negedge clk_i);
    clr_evt();
    rd(2'd3, d); check("R9 not before delay", d, 32'd0);
    @(negedge clk_i);
    rd(2'd3, d); check("R9 landed", d, 32'd3);

    // R2 count write wins over increment
    wr(2'd2, 32'd3); wr(2'd3, 32'd100);
    st_grad_i = 1'b1;
    wr(2'd3, 32'd50);
    clr_evt();
    rd(2'd3, d); check("R2 write beats increment", d, 32'd50);
    st_grad_i = 1'b1;
    @(negedge clk_i);
    clr_evt();
    rd(2'd3, d); check("R7 after write", d, 32'd51);
    rd(2'd2, d); check("R2 ctl1 readback", d, 32'd3);

    // R12 in-flight delayed increment dropped by control write
    wr(2'd0, 32'd3); wr(2'd1, 32'd0);
    st_issue_i = 1'b1;
    @(negedge clk_i);
    clr_evt();
    wr(2'd0, 32'd3);
    repeat (2) @(negedge clk_i);
    rd(2'd1, d); check("R12 in-flight dropped", d, 32'd0);

    // R12 immediate event during control write
    wr(2'd0, 32'd5); wr(2'd1, 32'd7);
    sc_fail_i = 1'b1;
    wr(2'd0, 32'd5);
    clr_evt();
    @(negedge clk_i);
    rd(2'd1, d); check("R12 no increment on ctl write", d, 32'd7);

    // R11 overflow on counter 0
    wr(2'd0, 32'd5); wr(2'd1, 32'hFFFF_FFFF);
    check("R11 no ovf before wrap", 32'(ovf_o), 32'h0);
    sc_fail_i = 1'b1;
    @(negedge clk_i);
    clr_evt();
    rd(2'd1, d); check("R11 wrap value", d, 32'h0);
    check("R11 ovf0 set", 32'(ovf_o), 32'h1);
    rd(2'd0, d); check("R11 ctl0 shows flag", d, 32'h105);
    sc_fail_i = 1'b1;
    @(negedge clk_i);
    clr_evt();
    check("R11 flag sticky", 32'(ovf_o), 32'h1);
    wr(2'd0, 32'd5);
    check("R11 write 0 keeps flag", 32'(ovf_o), 32'h1);
    wr(2'd0, 32'h105);
    check("R11 write 1 clears flag", 32'(ovf_o), 32'h0);
    rd(2'd0, d); check("R11 ctl0 after clear", d, 32'h5);

    // R11 multi-count wrap on counter 1
    wr(2'd2, 32'd5); wr(2'd3, 32'hFFFF_FFFE);
    fp_grad_cnt_i = 3'd4;
    @(negedge clk_i);
    clr_evt();
    @(negedge clk_i);
    rd(2'd3, d); check("R11 counter1 wrap value", d, 32'd2);
    check("R11 ovf1 set", 32'(ovf_o), 32'h2);

    finish_run();
  end

endmodule